// File: doc/BRIEF.md
# Bidirectional Saturating Barrel Shifter

This block shifts a 32-bit word by a signed 7-bit amount. The sign of the amount sets the direction, so a negative count turns a left shift into a right shift and the reverse. There are two operation families, "shift left" and "shift right". Each has an arithmetic form, which treats the source as signed, and a logical form, which treats it as unsigned.

The arithmetic forms can saturate. When a left-moving shift would lose the sign or the magnitude of the original word, the result is clamped to the extreme value that has the sign of that word, and an overflow flag is raised. The shift itself is combinational. One register stage with a synchronous active-low reset holds the result and the flag, so each result appears one clock after its inputs.

Internally the source is extended to 64 bits before it is shifted. A reverse shift by a magnitude m is done as a shift by m-1 followed by a shift by one. This keeps a magnitude of 64 well defined.

Top module: `bidir_sat_shifter`

## Requirements
- R1: While rst_n is low at a rising clock edge, res_o and ovf_o are cleared to zero on that edge. Otherwise the outputs take the result of the inputs sampled on the previous rising edge, a latency of one cycle.
- R2: op_i[1] selects the family: 0 is shift-left and 1 is shift-right. op_i[0] selects the variant: 0 is arithmetic (source sign-extended) and 1 is logical (source zero-extended).
- R3: For the shift-left family with a non-negative amt_i, res_o is the low 32 bits of the source shifted left by amt_i, so amounts of 32 or more give zero unless R7 applies.
- R4: For the shift-left family with a negative amt_i, res_o is the source shifted right by -amt_i. The arithmetic variant fills with the sign bit and the logical variant fills with zero. At amt_i = -64 the result is all sign bits (arithmetic) or zero (logical).
- R5: For the shift-right family with a non-negative amt_i, res_o is the source shifted right by amt_i, with a sign fill (arithmetic) or a zero fill (logical).
- R6: For the shift-right family with a negative amt_i, res_o is the low 32 bits of the source shifted left by -amt_i. At amt_i = -64 the result is zero unless R7 applies.
- R7: Saturation is active when sat_i is 1, the variant is arithmetic and the shift moves left. Let S be the exact 64-bit left shift of the sign-extended source. The result is clamped when any of these holds: S does not fit in 32 signed bits, bit 31 of S differs from bit 31 of the source, or the source is positive and S is zero. The clamped result is 0x7FFFFFFF for a non-negative source and 0x80000000 for a negative one.
- R8: ovf_o is 1 exactly when the R7 clamp replaces the result, and 0 otherwise.
- R9: sat_i has no effect on the logical variants or on any right-moving shift. This includes the arithmetic right path of the shift-left family.
- R10: An amt_i of zero returns the source unchanged with ovf_o at 0, for every operation and either sat_i value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Source word |
| amt_i | input | 7 | Signed shift amount, -64 to +63 |
| op_i | input | 2 | Bit 1: family (0 left, 1 right); bit 0: 0 arithmetic, 1 logical |
| sat_i | input | 1 | Saturate enable |
| res_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered saturation flag |

## Verification
The directed cases target the -64 amount in both families. A design that shifts by the magnitude in one step, or that wraps the magnitude to six bits, returns the source or a wrong fill there. They also target positive values that shift into the sign bit, negative values whose ones are all shifted out to zero, and a positive source that shifts to zero. A design that checks only truncated bits would miss each of these clamps. Other cases drive sat_i on logical operations and on right-moving arithmetic shifts; a design that saturates there raises a false overflow. Random vectors over all operations and amounts are compared with a reference model that works on 64-bit integers.

// File: rtl/bss_pkg.sv
// Shared definitions for the bidirectional saturating shifter.
// Assumes the two-bit operation code described in the brief.
package bss_pkg;
    // Operation codes: bit 1 picks the family, bit 0 picks logical.
    typedef enum logic [1:0] {
        BSS_OP_ASL = 2'b00,
        BSS_OP_LSL = 2'b01,
        BSS_OP_ASR = 2'b10,
        BSS_OP_LSR = 2'b11
    } bss_op_e;

    localparam int BSS_OPB_DIR   = 1;
    localparam int BSS_OPB_LOGIC = 0;
endpackage

// File: rtl/bss_shift_core.sv
// Direction-aware shift in a doubled-width domain.
// The source is extended to 2*W bits (sign or zero fill) and shifted.
// A reverse shift by magnitude m is done as (m-1) and then 1 more bit,
// so a magnitude of 2^(AW-1) stays well defined.
// Assumes amt is AW-bit two's complement.
module bss_shift_core #(
    parameter int W  = 32,
    parameter int AW = 7
) (
    input  logic [W-1:0]    src,
    input  logic [AW-1:0]   amt,
    input  logic            fam_right,
    input  logic            logic_var,
    output logic [2*W-1:0]  shifted,
    output logic            moves_left
);
    localparam int EW = 2 * W;

    logic            amt_neg;
    logic [AW-1:0]   mag_m1;
    logic [EW-1:0]   ext;
    logic [EW-1:0]   fwd_left;
    logic [EW-1:0]   rev_left;
    logic [EW-1:0]   fwd_right;
    logic [EW-1:0]   rev_right;

    // Decode sign and reverse magnitude minus one (~amt == -amt-1).
    always_comb begin
        amt_neg = amt[AW-1];
        mag_m1  = ~amt;
    end

    // Extend the source per variant.
    always_comb begin
        ext = logic_var ? {{W{1'b0}}, src} : {{W{src[W-1]}}, src};
    end

    // Left-moving paths: forward uses amt, reverse uses split magnitude.
    always_comb begin
        fwd_left = ext << amt;
        rev_left = (ext << mag_m1) << 1;
    end

    // Right-moving paths with fill chosen by variant.
    always_comb begin
        if (logic_var) begin
            fwd_right = ext >> amt;
            rev_right = (ext >> mag_m1) >> 1;
        end else begin
            fwd_right = EW'($signed(ext) >>> amt);
            rev_right = EW'($signed(EW'($signed(ext) >>> mag_m1)) >>> 1);
        end
    end

    // Select by family and amount sign.
    always_comb begin
        moves_left = fam_right ? amt_neg : ~amt_neg;
        case ({fam_right, amt_neg})
            2'b00:   shifted = fwd_left;
            2'b01:   shifted = rev_right;
            2'b10:   shifted = fwd_right;
            default: shifted = rev_left;
        endcase
    end
endmodule

// File: rtl/bss_clamp.sv
// Saturation stage: clamps a doubled-width left shift result to W bits
// with the extreme that matches the original operand's sign.
// Assumes sat_en is already gated to arithmetic left-moving shifts.
module bss_clamp #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] shifted,
    input  logic [W-1:0]   orig,
    input  logic           sat_en,
    output logic [W-1:0]   result,
    output logic           clamped
);
    localparam int EW = 2 * W;
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic fits;
    logic sign_flip;
    logic pos_to_zero;

    // Detect the three loss conditions.
    always_comb begin
        fits        = (&shifted[EW-1:W-1]) | ~(|shifted[EW-1:W-1]);
        sign_flip   = shifted[W-1] ^ orig[W-1];
        pos_to_zero = ~orig[W-1] & (|orig) & ~(|shifted);
        clamped     = sat_en & (~fits | sign_flip | pos_to_zero);
    end

    // Pick the clamp extreme or pass the low word.
    always_comb begin
        if (clamped) result = orig[W-1] ? MAX_NEG : MAX_POS;
        else         result = shifted[W-1:0];
    end
endmodule

// File: rtl/bidir_sat_shifter.sv
// Top of the bidirectional saturating shifter.
// Combinational shift and clamp followed by one output register stage.
// Assumes synchronous active-low reset and op codes from bss_pkg.
module bidir_sat_shifter #(
    parameter int W  = 32,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_i,
    input  logic [AW-1:0] amt_i,
    input  logic [1:0]    op_i,
    input  logic          sat_i,
    output logic [W-1:0]  res_o,
    output logic          ovf_o
);
    import bss_pkg::*;

    localparam int EW = 2 * W;

    logic [EW-1:0] shifted;
    logic          moves_left;
    logic          sat_gate;
    logic [W-1:0]  res_d;
    logic          ovf_d;

    bss_shift_core #(.W(W), .AW(AW)) u_core (
        .src        (src_i),
        .amt        (amt_i),
        .fam_right  (op_i[BSS_OPB_DIR]),
        .logic_var  (op_i[BSS_OPB_LOGIC]),
        .shifted    (shifted),
        .moves_left (moves_left)
    );

    // Saturation only for arithmetic left-moving shifts.
    always_comb begin
        sat_gate = sat_i & ~op_i[BSS_OPB_LOGIC] & moves_left;
    end

    bss_clamp #(.W(W)) u_clamp (
        .shifted (shifted),
        .orig    (src_i),
        .sat_en  (sat_gate),
        .result  (res_d),
        .clamped (ovf_d)
    );

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            res_o <= res_d;
            ovf_o <= ovf_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !ovf_o)); // R1

    AST_OVF_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (res_o == {1'b0, {(W-1){1'b1}}} || res_o == {1'b1, {(W-1){1'b0}}})); // R7

    AST_NO_SAT_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_i || op_i[BSS_OPB_LOGIC]) |=> !ovf_o); // R9

    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_i == '0) |=> (res_o == $past(src_i) && !ovf_o)); // R10

    AST_LOGIC_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BSS_OP_LSR && !amt_i[AW-1] && amt_i != '0) |=> !res_o[W-1]); // R5
endmodule

// File: tb/bidir_sat_shifter_bench.sv
module bidir_sat_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_i;
    logic [6:0]  amt_i;
    logic [1:0]  op_i;
    logic        sat_i;
    logic [31:0] res_o;
    logic        ovf_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bidir_sat_shifter u_bidir_sat_shifter (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .amt_i(amt_i),
        .op_i(op_i), .sat_i(sat_i), .res_o(res_o), .ovf_o(ovf_o)
    );

    function automatic logic [32:0] model(input logic [31:0] s, input logic [6:0] a7,
                                          input logic [1:0] op, input logic sat);
        int a;
        int m;
        logic lft;
        logic [63:0] e;
        logic [63:0] f;
        logic fit;
        logic cl;
        a   = int'($signed(a7));
        m   = (a < 0) ? -a : a;
        lft = op[1] ? (a < 0) : (a >= 0);
        e   = op[0] ? {32'b0, s} : {{32{s[31]}}, s};
        if (lft)        f = (m >= 64) ? 64'b0 : (e << m);
        else if (op[0]) f = (m >= 64) ? 64'b0 : (e >> m);
        else            f = (m >= 64) ? {64{e[63]}} : 64'($signed(e) >>> m);
        fit = (f[63:31] == '0) || (f[63:31] == '1);
        cl  = sat && !op[0] && lft &&
              (!fit || (f[31] != s[31]) || (s != 0 && !s[31] && f == 0));
        if (cl) return {1'b1, s[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
        return {1'b0, f[31:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_o);
        n_cmp++;
        if (res_o !== exp_r || ovf_o !== exp_o) begin
            n_bad++;
            $display("FAIL %s: got res=%h ovf=%b, expected res=%h ovf=%b",
                     tag, res_o, ovf_o, exp_r, exp_o);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] s, input logic [6:0] a,
                         input logic [1:0] op, input logic sat,
                         input logic [31:0] exp_r, input logic exp_o);
        src_i = s; amt_i = a; op_i = op; sat_i = sat;
        @(negedge clk);
        check(tag, exp_r, exp_o);
    endtask

    task automatic apply_m(input string tag, input logic [31:0] s, input logic [6:0] a,
                           input logic [1:0] op, input logic sat);
        logic [32:0] x;
        x = model(s, a, op, sat);
        apply(tag, s, a, op, sat, x[31:0], x[32]);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        rst_n = 1'b0; src_i = 32'hDEAD_BEEF; amt_i = 7'd3; op_i = 2'b00; sat_i = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 reset clears", 32'h0, 1'b0);
        rst_n = 1'b1;
        // R3 left forward
        apply("R3 asl 4",     32'h0000_1234, 7'd4,  2'b00, 1'b0, 32'h0001_2340, 1'b0);
        apply("R3 lsl 40",    32'hFFFF_FFFF, 7'd40, 2'b01, 1'b0, 32'h0, 1'b0);
        // R4 left op, negative amount
        apply("R4 asl -4",    32'h8000_0000, 7'h7C, 2'b00, 1'b0, 32'hF800_0000, 1'b0);
        apply("R4 lsl -4",    32'h8000_0000, 7'h7C, 2'b01, 1'b0, 32'h0800_0000, 1'b0);
        apply("R4 asl -64",   32'h8000_0001, 7'h40, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0);
        apply("R4 lsl -64",   32'hFFFF_FFFF, 7'h40, 2'b01, 1'b0, 32'h0, 1'b0);
        // R9 arithmetic right path of the left op never saturates
        apply("R9 asl -1 sat", 32'h8000_0001, 7'h7F, 2'b00, 1'b1, 32'hC000_0000, 1'b0);
        // R5 right forward
        apply("R5 asr 8",     32'hF000_0F00, 7'd8,  2'b10, 1'b0, 32'hFFF0_000F, 1'b0);
        apply("R5 lsr 8",     32'hF000_0F00, 7'd8,  2'b11, 1'b0, 32'h00F0_000F, 1'b0);
        apply("R5 asr 63",    32'h8000_0000, 7'd63, 2'b10, 1'b1, 32'hFFFF_FFFF, 1'b0);
        // R6 right op, negative amount
        apply("R6 asr -3",    32'h0000_0011, 7'h7D, 2'b10, 1'b0, 32'h0000_0088, 1'b0);
        apply("R6 lsr -64",   32'hFFFF_FFFF, 7'h40, 2'b11, 1'b0, 32'h0, 1'b0);
        // R7 / R8 saturation
        apply("R7 pos into sign",  32'h4000_0000, 7'd1,  2'b00, 1'b1, 32'h7FFF_FFFF, 1'b1);
        apply("R8 neg fits",       32'hFFFF_FFFF, 7'd31, 2'b00, 1'b1, 32'h8000_0000, 1'b0);
        apply("R7 neg lost",       32'h8000_0000, 7'd33, 2'b00, 1'b1, 32'h8000_0000, 1'b1);
        apply("R7 pos to zero",    32'h0000_0001, 7'h40, 2'b10, 1'b1, 32'h7FFF_FFFF, 1'b1);
        apply("R7 rev neg clamp",  32'hC000_0000, 7'h7E, 2'b10, 1'b1, 32'h8000_0000, 1'b1);
        apply("R8 zero src",       32'h0,         7'd20, 2'b00, 1'b1, 32'h0, 1'b0);
        // R9 logical ignores sat
        apply("R9 lsl sat",        32'h4000_0000, 7'd1,  2'b01, 1'b1, 32'h8000_0000, 1'b0);
        apply("R9 lsr -1 sat",     32'h4000_0000, 7'h7F, 2'b11, 1'b1, 32'h8000_0000, 1'b0);
        // R10 zero amount
        for (int op = 0; op < 4; op++)
            apply("R10 zero amt", 32'h8765_4321, 7'd0, 2'(op), 1'b1, 32'h8765_4321, 1'b0);
        // R2 mixed random against model (covers R3-R9)
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] s;
            s = $urandom();
            if (i % 4 == 1) s = s >> ($urandom() % 32);
            if (i % 4 == 2) s = {32{1'b1}} << ($urandom() % 32);
            apply_m("R2 random", s, 7'($urandom()), 2'($urandom()), 1'($urandom()));
        end
        // R1 reset mid-stream
        rst_n = 1'b0;
        apply("R1 reset again", 32'h7FFF_FFFF, 7'd5, 2'b00, 1'b1, 32'h0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule